// File: doc/BRIEF.md
# Half-Duplex Ethernet Transmit Controller

This block moves one frame at a time from an output queue onto a two-bit reduced media-independent transmit interface. It reads frame bytes from a first-word-fall-through queue and puts a preamble and start delimiter in front of them. It serializes every byte as four dibits and then holds a quiet gap before it starts another frame. The frame check sequence is already in the queued bytes, so the block adds none.

On a half-duplex link the block waits while the carrier is present. If a collision is seen early in a frame, the block sends a short jam. It then asks the queue to rewind to the frame start and waits a random number of slot times that grows with each attempt, and then retries. A collision that arrives after the late-collision threshold ends the frame at once, with no jam and no retry. A frame that collides on every one of its allowed attempts is discarded. On a full-duplex link the carrier and collision inputs have no effect.

Single-cycle status pulses report each outcome: completion, late abort, discard, or rewind-for-retry. The queue uses them to release the frame or to restart it.

Top module: `hdx_tx_mac`

## Requirements
- R1: After reset `tx_en`, `rd_en` and all four status pulses are low, and `tx_en` never rises while `frame_ready` is low.
- R2: Every attempt begins with 32 dibits: 31 of value 01 and then one of 11. These are seven 0x55 bytes and one 0xD5 byte, each sent bits [1:0] first.
- R3: After the preamble, each queued byte goes out as four dibits in the order bits [1:0], [3:2], [5:4], [7:6]. `tx_done` pulses during the final dibit of the byte flagged `rd_last`.
- R4: Two frames are separated by at least `IPG_DIBITS` cycles with `tx_en` low. The gap is exactly `IPG_DIBITS` when the next frame is already waiting.
- R5: In half duplex, a collision at dibit index below `LATE_DIBITS` of an attempt (index 0 being the first preamble dibit) is followed by `JAM_DIBITS` cycles of `txd`=10. `tx_rewind` pulses in the last jam cycle.
- R6: After the n-th collision of a frame, the `tx_en`-low gap before the retry is at least `IPG_DIBITS`. It is at most the larger of `IPG_DIBITS` and `(2^min(n,BACKOFF_CAP)-1)*SLOT_DIBITS+2`.
- R7: In half duplex, a collision at dibit index `LATE_DIBITS` or later pulses `tx_abort` in that cycle. `tx_en` is low on the next cycle, and there is no jam and no rewind.
- R8: On the `MAX_ATTEMPTS`-th early collision of a frame the jam is still sent. Its last cycle then pulses `tx_drop` instead of `tx_rewind`, and the next frame starts with a fresh attempt count.
- R9: With `full_duplex` high, `crs` and `col` change neither the transmitted dibits, nor the gap, nor the status: frames always complete.
- R10: A late collision in the cycle of a frame's final dibit wins over completion: `tx_abort` pulses and `tx_done` does not.
- R11: In half duplex, no frame starts while `crs` is high. A waiting frame starts on the cycle after `crs` falls, once the gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one dibit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half duplex |
| crs | input | 1 | Carrier sense from the PHY |
| col | input | 1 | Collision indication from the PHY |
| frame_ready | input | 1 | Queue holds a complete frame |
| rd_data | input | 8 | Current queue byte (first-word fall-through) |
| rd_last | input | 1 | Current byte is the frame's final byte |
| rd_en | output | 1 | Pops the current byte |
| txd | output | 2 | Transmit dibit |
| tx_en | output | 1 | Transmit enable |
| tx_done | output | 1 | Frame fully sent |
| tx_abort | output | 1 | Frame ended by late collision |
| tx_drop | output | 1 | Frame discarded after too many collisions |
| tx_rewind | output | 1 | Queue must restart the frame for a retry |

## Verification
Completion and collision can land in the same cycle, because a collision may arrive on the dibit that carries the end of the last byte. The bench places a collision exactly on that final dibit twice. With a five-byte frame the dibit lies past the late threshold, so it must give `tx_abort` and no `tx_done`. With a four-byte frame the final dibit sits one below the threshold, so it must give a jam and a rewind, again with no completion. The late threshold is also probed from both sides on one frame: index `LATE_DIBITS-1` must jam and `LATE_DIBITS` must abort.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_JAM,
    ST_BACKOFF
  } tx_state_e;

  // Highest slot count allowed after the n-th collision: 2^min(n,cap)-1.
  function automatic int unsigned backoff_mask(int unsigned n, int unsigned cap);
    int unsigned e;
    e = (n < cap) ? n : cap;
    return (32'd1 << e) - 32'd1;
  endfunction

  // Preamble dibit: 01 everywhere except the last dibit of the delimiter.
  function automatic logic [1:0] preamble_dibit(logic is_last);
    return is_last ? 2'b11 : 2'b01;
  endfunction

  // Dibit i of a byte, low bits first.
  function automatic logic [1:0] pick_dibit(logic [7:0] b, logic [1:0] i);
    return b[2*i +: 2];
  endfunction

endpackage

// File: rtl/hdx_tx_lfsr.sv
module hdx_tx_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1ACE,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SEED;
    else if (st[0]) st <= (st >> 1) ^ TAPS;
    else st <= st >> 1;
  end

  assign rnd = st[OUT_W-1:0];
endmodule

// File: rtl/hdx_tx_gap.sv
module hdx_tx_gap #(
  parameter int IPG_DIBITS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  output logic gap_ok
);
  localparam int GW = $clog2(IPG_DIBITS + 1);
  localparam logic [GW-1:0] SAT = GW'(IPG_DIBITS);
  localparam logic [GW-1:0] OK_AT = GW'(IPG_DIBITS - 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= SAT;
    else if (tx_en) cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign gap_ok = (cnt >= OK_AT);
endmodule

// File: rtl/hdx_tx_backoff.sv
module hdx_tx_backoff
  import hdx_tx_pkg::*;
#(
  parameter int SLOT_DIBITS = 256,
  parameter int BACKOFF_CAP = 10,
  parameter int ATT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [ATT_W-1:0]       attempts,
  input  logic [BACKOFF_CAP-1:0] rnd,
  output logic                   done
);
  localparam int SW = (SLOT_DIBITS > 1) ? $clog2(SLOT_DIBITS) : 1;
  localparam logic [SW-1:0] SLOT_END = SW'(SLOT_DIBITS - 1);

  logic                   active;
  logic [BACKOFF_CAP-1:0] slots;
  logic [SW-1:0]          cyc;
  logic [31:0]            mask_full;

  assign mask_full = backoff_mask(32'(attempts), BACKOFF_CAP);
  assign done = active && (slots == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slots  <= '0;
      cyc    <= '0;
    end else if (load) begin
      active <= 1'b1;
      slots  <= rnd & mask_full[BACKOFF_CAP-1:0];
      cyc    <= '0;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      if (cyc == SLOT_END) begin
        cyc   <= '0;
        slots <= slots - 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdx_tx_mac.sv
module hdx_tx_mac
  import hdx_tx_pkg::*;
#(
  parameter int IPG_DIBITS   = 48,
  parameter int SLOT_DIBITS  = 256,
  parameter int LATE_DIBITS  = 256,
  parameter int JAM_DIBITS   = 16,
  parameter int MAX_ATTEMPTS = 16,
  parameter int BACKOFF_CAP  = 10,
  parameter int LFSR_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic       crs,
  input  logic       col,
  input  logic       frame_ready,
  input  logic [7:0] rd_data,
  input  logic       rd_last,
  output logic       rd_en,
  output logic [1:0] txd,
  output logic       tx_en,
  output logic       tx_done,
  output logic       tx_abort,
  output logic       tx_drop,
  output logic       tx_rewind
);
  localparam int CNT_W = $clog2(LATE_DIBITS + 1);
  localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam int JAM_W = (JAM_DIBITS > 1) ? $clog2(JAM_DIBITS) : 1;
  localparam logic [CNT_W-1:0] LATE_L = CNT_W'(LATE_DIBITS);
  localparam logic [ATT_W-1:0] MAX_L  = ATT_W'(MAX_ATTEMPTS);
  localparam logic [JAM_W-1:0] JAM_END = JAM_W'(JAM_DIBITS - 1);

  tx_state_e        state;
  logic [4:0]       pre_cnt;
  logic [1:0]       dib;
  logic [7:0]       shreg;
  logic             last_q;
  logic [CNT_W-1:0] tx_cnt;
  logic [ATT_W-1:0] attempts;
  logic [JAM_W-1:0] jam_cnt;

  // Named internal events
  logic half, sending, coll_hit, late_hit, early_hit;
  logic pre_end, byte_end, start_go, jam_end, give_up;
  logic gap_ok, bo_done;
  logic [BACKOFF_CAP-1:0] rnd;

  hdx_tx_lfsr #(.W(LFSR_W), .OUT_W(BACKOFF_CAP)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  hdx_tx_gap #(.IPG_DIBITS(IPG_DIBITS)) u_gap (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .gap_ok(gap_ok)
  );

  hdx_tx_backoff #(
    .SLOT_DIBITS(SLOT_DIBITS), .BACKOFF_CAP(BACKOFF_CAP), .ATT_W(ATT_W)
  ) u_bo (
    .clk(clk), .rst_n(rst_n), .load(tx_rewind), .attempts(attempts),
    .rnd(rnd), .done(bo_done)
  );

  assign half      = !full_duplex;
  assign sending   = (state == ST_PRE) || (state == ST_DATA);
  assign coll_hit  = half && col && sending;
  assign late_hit  = coll_hit && (tx_cnt >= LATE_L);
  assign early_hit = coll_hit && !late_hit;
  assign pre_end   = (state == ST_PRE) && (pre_cnt == 5'd31);
  assign byte_end  = (state == ST_DATA) && (dib == 2'd3);
  assign start_go  = (state == ST_IDLE) && frame_ready && gap_ok && !(half && crs);
  assign jam_end   = (state == ST_JAM) && (jam_cnt == JAM_END);
  assign give_up   = (attempts == MAX_L);

  assign tx_en     = sending || (state == ST_JAM);
  assign tx_done   = byte_end && last_q && !coll_hit;
  assign tx_abort  = late_hit;
  assign tx_drop   = jam_end && give_up;
  assign tx_rewind = jam_end && !give_up;
  assign rd_en     = (pre_end || (byte_end && !last_q)) && !coll_hit;

  always_comb begin
    unique case (state)
      ST_PRE:  txd = preamble_dibit(pre_cnt == 5'd31);
      ST_DATA: txd = pick_dibit(shreg, dib);
      ST_JAM:  txd = 2'b10;
      default: txd = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pre_cnt  <= '0;
      dib      <= '0;
      shreg    <= '0;
      last_q   <= 1'b0;
      tx_cnt   <= '0;
      attempts <= '0;
      jam_cnt  <= '0;
    end else begin
      if (sending && tx_cnt != LATE_L) tx_cnt <= tx_cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (start_go) begin
          state   <= ST_PRE;
          pre_cnt <= '0;
          tx_cnt  <= '0;
        end
        ST_PRE, ST_DATA: begin
          if (late_hit) begin
            state    <= ST_IDLE;
            attempts <= '0;
          end else if (early_hit) begin
            state    <= ST_JAM;
            jam_cnt  <= '0;
            attempts <= attempts + 1'b1;
          end else if (pre_end || (byte_end && !last_q)) begin
            state  <= ST_DATA;
            dib    <= '0;
            shreg  <= rd_data;
            last_q <= rd_last;
          end else if (byte_end) begin
            state    <= ST_IDLE;
            attempts <= '0;
          end else if (state == ST_PRE) begin
            pre_cnt <= pre_cnt + 1'b1;
          end else begin
            dib <= dib + 1'b1;
          end
        end
        ST_JAM: begin
          if (jam_end) begin
            state <= give_up ? ST_IDLE : ST_BACKOFF;
            if (give_up) attempts <= '0;
          end else begin
            jam_cnt <= jam_cnt + 1'b1;
          end
        end
        ST_BACKOFF: if (bo_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_tx_mac_chk.sv
module hdx_tx_mac_chk (
  input logic clk,
  input logic rst_n,
  input logic full_duplex,
  input logic crs,
  input logic frame_ready,
  input logic tx_en,
  input logic tx_done,
  input logic tx_abort,
  input logic tx_drop,
  input logic tx_rewind,
  input logic coll_hit,
  input logic late_hit
);
  AST_IDLE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !frame_ready) |=> !tx_en); // R1
  AST_DONE_OPENS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_en); // R4
  AST_EARLY_COLL_JAMS: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_hit && !late_hit) |=> tx_en); // R5
  AST_ABORT_STOPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> !tx_en); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done, tx_abort, tx_drop, tx_rewind})); // R8
  AST_FDX_NO_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> !(tx_abort || tx_drop || tx_rewind)); // R9
  AST_COLL_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    coll_hit |-> !tx_done); // R10
  AST_DEFER_ON_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !full_duplex && crs) |=> !tx_en); // R11
endmodule

bind hdx_tx_mac hdx_tx_mac_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs),
  .frame_ready(frame_ready), .tx_en(tx_en), .tx_done(tx_done),
  .tx_abort(tx_abort), .tx_drop(tx_drop), .tx_rewind(tx_rewind),
  .coll_hit(coll_hit), .late_hit(late_hit)
);

// File: tb/hdx_tx_mac_tb.sv
module hdx_tx_mac_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IPG  = 6;
  localparam int SLOT = 4;
  localparam int LATE = 48;
  localparam int JAM  = 8;
  localparam int MAXA = 16;
  localparam int CAP  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 1'b0, crs = 1'b0, col = 1'b0;
  logic frame_ready, rd_last, rd_en, tx_en, tx_done, tx_abort, tx_drop, tx_rewind;
  logic [7:0] rd_data;
  logic [1:0] txd;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] fmem [0:15];
  int flen = 0, fptr = 0;
  bit have = 0;
  logic [1:0] cap [0:255];
  int cap_n;
  bit s_done, s_abort, s_drop, s_rew;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign frame_ready = have;
  assign rd_data = fmem[fptr[3:0]];
  assign rd_last = (fptr == flen - 1);

  always @(posedge clk) begin
    if (tx_rewind) fptr <= 0;
    else if (rd_en) fptr <= fptr + 1;
  end

  hdx_tx_mac #(.IPG_DIBITS(IPG), .SLOT_DIBITS(SLOT), .LATE_DIBITS(LATE),
               .JAM_DIBITS(JAM), .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs), .col(col),
    .frame_ready(frame_ready), .rd_data(rd_data), .rd_last(rd_last), .rd_en(rd_en),
    .txd(txd), .tx_en(tx_en), .tx_done(tx_done), .tx_abort(tx_abort),
    .tx_drop(tx_drop), .tx_rewind(tx_rewind)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int max_gap(input int n);
    int e = (n < CAP) ? n : CAP;
    int bo = ((2 ** e) - 1) * SLOT + 2;
    return (bo > IPG) ? bo : IPG;
  endfunction

  task automatic load(input int len, input int seed);
    for (int i = 0; i < len; i++) fmem[i] = 8'((seed * 37 + i * 11 + len) & 255);
    flen = len;
    fptr = 0;
    have = 1;
  endtask

  // Called at a negedge with tx_en low; returns at the negedge of dibit 0.
  task automatic wait_start(output int gap);
    gap = 0;
    while (!tx_en && gap <= 20000) begin
      gap++;
      @(negedge clk);
    end
    if (gap > 20000) chk(0, "R1 start timeout", gap, 0);
  endtask

  task automatic capture(input int col_at);
    cap_n = 0; s_done = 0; s_abort = 0; s_drop = 0; s_rew = 0;
    while (tx_en) begin
      if (cap_n < 256) cap[cap_n] = txd;
      col = (cap_n == col_at);
      #1;
      if (tx_done) s_done = 1;
      if (tx_abort) s_abort = 1;
      if (tx_drop) s_drop = 1;
      if (tx_rewind) s_rew = 1;
      if (tx_done || tx_abort || tx_drop) have = 0;
      cap_n++;
      @(negedge clk);
    end
    col = 0;
  endtask

  task automatic check_frame(input int len, input string req);
    int bad_pre = 0;
    chk(cap_n == 32 + 4 * len, {req, " R3 length"}, cap_n, 32 + 4 * len);
    for (int i = 0; i < 32; i++)
      if (cap[i] != ((i == 31) ? 2'b11 : 2'b01)) bad_pre++;
    chk(bad_pre == 0, {req, " R2 preamble"}, bad_pre, 0);
    for (int k = 0; k < len; k++) begin
      int b = cap[32+4*k] + 4 * cap[33+4*k] + 16 * cap[34+4*k] + 64 * cap[35+4*k];
      chk(b == int'(fmem[k]), {req, " R3 byte"}, b, int'(fmem[k]));
    end
    chk(s_done && !s_abort && !s_drop && !s_rew, {req, " R3 done"}, s_done, 1);
  endtask

  task automatic check_jam(input int col_at, input string req);
    int bad = 0;
    chk(cap_n == col_at + 1 + JAM, {req, " R5 jam length"}, cap_n, col_at + 1 + JAM);
    for (int i = col_at + 1; i < cap_n && i < 256; i++) if (cap[i] != 2'b10) bad++;
    chk(bad == 0, {req, " R5 jam pattern"}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    int g;
    int stray;
    // R1: reset state and no start without a frame
    repeat (3) @(negedge clk);
    chk({tx_en, rd_en, tx_done, tx_abort, tx_drop, tx_rewind} == 6'b0, "R1 reset", tx_en, 0);
    rst_n = 1;
    stray = 0;
    repeat (20) begin @(negedge clk); if (tx_en || rd_en) stray++; end
    chk(stray == 0, "R1 idle without frame", stray, 0);

    // R2 R3 R4: length sweep, back to back
    for (int len = 1; len <= 6; len++) begin
      load(len, len);
      wait_start(g);
      if (len > 1) chk(g == IPG, "R4 gap", g, IPG);
      capture(-1);
      check_frame(len, "sweep");
    end

    // R11: defer on carrier
    crs = 1;
    load(3, 7);
    stray = 0;
    repeat (30) begin @(negedge clk); if (tx_en) stray++; end
    chk(stray == 0, "R11 defer", stray, 0);
    crs = 0;
    wait_start(g);
    chk(g == 1, "R11 start after crs falls", g, 1);
    capture(-1);
    check_frame(3, "R11");

    // R9: full duplex ignores crs and col
    full_duplex = 1; crs = 1;
    load(4, 9);
    wait_start(g);
    chk(g == IPG, "R9 gap with crs", g, IPG);
    capture(10);
    check_frame(4, "R9 early col");
    load(12, 3);
    wait_start(g);
    capture(60);
    check_frame(12, "R9 late col");
    full_duplex = 0; crs = 0;

    // R5 R6: one collision then success
    load(10, 4);
    wait_start(g);
    capture(20);
    check_jam(20, "one");
    chk(s_rew && !s_done && !s_abort, "R5 rewind", s_rew, 1);
    wait_start(g);
    chk(g >= IPG && g <= max_gap(1), "R6 backoff n=1", g, max_gap(1));
    capture(-1);
    check_frame(10, "R5 retry");

    // R5 R6: two collisions (preamble, then data) then success
    load(10, 5);
    wait_start(g);
    capture(3);
    check_jam(3, "pre");
    wait_start(g);
    chk(g >= IPG && g <= max_gap(1), "R6 backoff n=1b", g, max_gap(1));
    capture(40);
    check_jam(40, "data");
    chk(s_rew, "R5 second rewind", s_rew, 1);
    wait_start(g);
    chk(g >= IPG && g <= max_gap(2), "R6 backoff n=2", g, max_gap(2));
    capture(-1);
    check_frame(10, "R6 retry");

    // R7: late threshold from both sides
    load(5, 6);
    wait_start(g);
    capture(LATE - 1);
    check_jam(LATE - 1, "edge");
    chk(s_rew && !s_abort, "R7 below threshold is early", s_abort, 0);
    wait_start(g);
    capture(LATE);
    chk(s_abort && !s_rew && !s_done, "R7 abort", s_abort, 1);
    chk(cap_n == LATE + 1, "R7 tx_en drops next cycle", cap_n, LATE + 1);

    // R10: collision on the final dibit
    load(5, 8);
    wait_start(g);
    capture(51);
    chk(s_abort && !s_done, "R10 late on last dibit", s_done, 0);
    chk(cap_n == 52, "R10 length", cap_n, 52);
    load(4, 2);
    wait_start(g);
    capture(47);
    chk(s_rew && !s_done, "R10 early on last dibit", s_done, 0);
    check_jam(47, "R10");
    wait_start(g);
    capture(-1);
    check_frame(4, "R10 retry");

    // R8: drop after MAXA collisions
    load(6, 1);
    for (int a = 1; a <= MAXA; a++) begin
      wait_start(g);
      if (a > 1) chk(g >= IPG && g <= max_gap(a - 1), "R6 backoff sweep", g, max_gap(a - 1));
      capture(5);
      if (a < MAXA) chk(s_rew && !s_drop, "R8 retry before limit", s_drop, 0);
      else begin
        chk(s_drop && !s_rew, "R8 drop at limit", s_drop, 1);
        check_jam(5, "R8");
      end
    end
    load(3, 3);
    wait_start(g);
    capture(2);
    wait_start(g);
    chk(g >= IPG && g <= max_gap(1), "R8 attempts restart", g, max_gap(1));
    capture(-1);
    check_frame(3, "R8 after drop");

    finish_run();
  end
endmodule